// File: doc/BRIEF.md
# Two-Wire Slave Byte Engine with Busy Polling

This block is the slave-side byte engine of a two-wire serial bus. It takes already synchronised clock and data line samples, recognises start and stop conditions, gathers bytes most significant bit first, and decides whether the first byte of a transfer selects this device. A byte selects the device when its top four bits equal a fixed type code and its next three bits equal the three strap inputs. The engine pulls the data line low in the ninth clock to acknowledge. It also shifts out bytes supplied by a downstream sequencer for as long as the master keeps acknowledging.

Each byte received during a write is handed to the downstream sequencer. The first byte after the slave address carries a flag, because it is the word address. A write transfer that delivered at least one payload byte and then ended with a stop condition starts an emulated nonvolatile write cycle of a configurable number of clocks. While that cycle runs, the engine treats its own address as foreign and never drives the line. A master polls for completion by sending the address byte until it receives an acknowledge.

A read sets the word address with a write-addressed transfer. A repeated start and a read-addressed transfer follow. The engine's data line output is an open-drain enable: when it is high, the line is pulled low.

Top module: `tws_slave_engine`

## Requirements
- R1: An address byte whose bits 7..4 differ from the type code (default 1010b) gets no acknowledge, and the engine stays silent until the next start.
- R2: Address byte bits 3..1 must equal strap pins 2..0 bit for bit (bit 3 against strap 2); on a mismatch the byte is not acknowledged.
- R3: A matching address byte is acknowledged with either value of bit 0. Bit 0 = 1 makes the transfer a read and bit 0 = 0 makes it a write; the match raises `addr_hit_o` for exactly one clock.
- R4: In a write transfer, every byte after the address is acknowledged and presented on `rx_data_o` with a one-clock `rx_valid_o`. `rx_first_o` is high only for the first such byte, which is the word address.
- R5: A stop ending a write transfer that carried at least one byte after the word address pulses `wr_commit_o`. On the next clock `busy_o` rises, and it then stays high for exactly WRITE_CYCLES clocks.
- R6: While `busy_o` is high, no address byte is acknowledged, `addr_hit_o` stays low and `sda_oe_o` stays low.
- R7: Once `busy_o` has fallen, a matching address byte with either value of bit 0 is acknowledged again, so a polling master can detect completion.
- R8: In a read transfer, `tx_data_i` is captured when each byte starts and sent most significant bit first. `tx_take_o` pulses once for each capture, so the sequencer can present the next byte.
- R9: After a sent byte, a master acknowledge (line low in the ninth clock) starts the next byte. A master no-acknowledge ends the transfer, leaves the line released and captures no further byte.
- R10: A start seen part way through a byte discards the partial byte and makes the next byte an address byte. A stop seen part way through a byte discards it without a handoff.
- R11: `sda_oe_o` changes value only in clocks in which the sampled clock line is low.
- R12: A write transfer that carried only the word address (or nothing) does not start a write cycle, whether it ends in a stop or in a repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line sample |
| sda_i | input | 1 | Synchronised bus data line sample |
| strap_i | input | 3 | Device address straps compared with address byte bits 3..1 |
| tx_data_i | input | 8 | Byte to send next in a read transfer |
| sda_oe_o | output | 1 | Open-drain enable; high pulls the data line low |
| addr_hit_o | output | 1 | One-clock pulse when an address byte selects the device |
| rw_o | output | 1 | Direction of the current transfer, 1 = read |
| rx_valid_o | output | 1 | One-clock pulse with each received write byte |
| rx_first_o | output | 1 | Marks the received byte as the word address |
| rx_data_o | output | 8 | Last received write byte |
| tx_take_o | output | 1 | One-clock pulse after `tx_data_i` has been captured |
| busy_o | output | 1 | Emulated nonvolatile write cycle in progress |
| wr_commit_o | output | 1 | One-clock pulse when a write cycle is launched |

## Verification
The bench builds the engine with WRITE_CYCLES = 200 and runs each bus half-period for four system clocks. With those values a poll issued right after the stop still lands inside the write cycle, and the end of the cycle follows within a few bytes' time. A whole busy-then-ready sequence therefore fits in a short run, and the busy length can be counted clock by clock. The default type code is kept, so the address table can exercise wrong type codes, wrong straps and both directions against the same strap settings.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int BYTE_W = 8;
  localparam int STRAP_W = 3;
  localparam int TYPE_W = BYTE_W - STRAP_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RECV,
    ST_RECV_ACK,
    ST_SEND,
    ST_SEND_ACK
  } tws_state_e;

  // Address byte without its direction bit: type code on top, straps below.
  function automatic logic addr_selects(input logic [BYTE_W-1:1] head,
                                        input logic [TYPE_W-1:0] code,
                                        input logic [STRAP_W-1:0] strap);
    return (head[BYTE_W-1 -: TYPE_W] == code) && (head[STRAP_W:1] == strap);
  endfunction

  // Bit counter value that marks a whole byte received or sent.
  function automatic logic byte_full(input logic [3:0] cnt);
    return cnt == 4'(BYTE_W);
  endfunction

endpackage

// File: rtl/tws_line_events.sv
module tws_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // Data moves with the clock line held high in two samples: start or stop.
  assign ev_start = scl_i && scl_q && sda_q && !sda_i;
  assign ev_stop  = scl_i && scl_q && !sda_q && sda_i;
  assign ev_rise  = scl_i && !scl_q;
  assign ev_fall  = !scl_i && scl_q;
endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_shift,
  input  logic              rx_bit,
  input  logic              tx_load,
  input  logic              tx_shift,
  input  logic [BYTE_W-2:0] tx_tail,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_next_bit
);
  // Only the bits still to be sent after the first are held.
  logic [BYTE_W-2:0] tx_rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      tx_rest <= '0;
    end else begin
      if (rx_shift) rx_byte <= {rx_byte[BYTE_W-2:0], rx_bit};
      if (tx_load) tx_rest <= tx_tail;
      else if (tx_shift) tx_rest <= {tx_rest[BYTE_W-3:0], 1'b0};
    end
  end

  assign tx_next_bit = tx_rest[BYTE_W-2];
endmodule

// File: rtl/tws_busy_timer.sv
module tws_busy_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else if (start) remain <= CW'(CYCLES);
    else if (remain != '0) remain <= remain - CW'(1);
  end

  assign busy = remain != '0;
endmodule

// File: rtl/tws_slave_engine.sv
module tws_slave_engine
  import tws_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [2:0]  strap_i,
  input  logic [7:0]  tx_data_i,
  output logic        sda_oe_o,
  output logic        addr_hit_o,
  output logic        rw_o,
  output logic        rx_valid_o,
  output logic        rx_first_o,
  output logic [7:0]  rx_data_o,
  output logic        tx_take_o,
  output logic        busy_o,
  output logic        wr_commit_o
);
  tws_state_e state;
  logic [3:0] bitcnt;
  logic       word_next;
  logic       data_seen;
  logic       master_ack;

  logic       ev_start, ev_stop, ev_rise, ev_fall;
  logic [7:0] rx_byte;
  logic       tx_next_bit;

  // Named internal events shared by the datapath and the checker.
  logic in_rx_state, rx_shift, tx_shift, load_now, addr_ok;

  tws_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  assign in_rx_state = (state == ST_ADDR) || (state == ST_RECV);
  assign rx_shift = ev_rise && in_rx_state && (bitcnt < 4'd8);
  assign tx_shift = ev_fall && (state == ST_SEND) && (bitcnt != 4'd0) && !byte_full(bitcnt);
  assign load_now = ev_fall && !ev_start && !ev_stop &&
                    (((state == ST_ADDR_ACK) && rw_o) || ((state == ST_SEND_ACK) && master_ack));
  assign addr_ok = !busy_o && addr_selects(rx_byte[7:1], TYPE_CODE, strap_i);

  tws_shift_unit #(.BYTE_W(BYTE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_shift    (rx_shift),
    .rx_bit      (sda_i),
    .tx_load     (load_now),
    .tx_shift    (tx_shift),
    .tx_tail     (tx_data_i[6:0]),
    .rx_byte     (rx_byte),
    .tx_next_bit (tx_next_bit)
  );

  tws_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_commit_o),
    .busy  (busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      word_next   <= 1'b0;
      data_seen   <= 1'b0;
      master_ack  <= 1'b0;
      sda_oe_o    <= 1'b0;
      addr_hit_o  <= 1'b0;
      rw_o        <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_first_o  <= 1'b0;
      rx_data_o   <= '0;
      tx_take_o   <= 1'b0;
      wr_commit_o <= 1'b0;
    end else begin
      addr_hit_o  <= 1'b0;
      rx_valid_o  <= 1'b0;
      tx_take_o   <= load_now;
      wr_commit_o <= 1'b0;
      if (rx_shift) bitcnt <= bitcnt + 4'd1;
      if (ev_start) begin
        state    <= ST_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (ev_stop) begin
        state    <= ST_IDLE;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
        if (data_seen) begin
          wr_commit_o <= 1'b1;
          data_seen   <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (ev_fall && byte_full(bitcnt)) begin
              if (addr_ok) begin
                sda_oe_o   <= 1'b1;
                rw_o       <= rx_byte[0];
                addr_hit_o <= 1'b1;
                state      <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RECV: begin
            if (ev_fall && byte_full(bitcnt)) begin
              sda_oe_o   <= 1'b1;
              rx_valid_o <= 1'b1;
              rx_data_o  <= rx_byte;
              rx_first_o <= word_next;
              if (!word_next) data_seen <= 1'b1;
              word_next  <= 1'b0;
              state      <= ST_RECV_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (ev_fall) begin
              bitcnt <= '0;
              if (rw_o) begin
                sda_oe_o <= !tx_data_i[7];
                state    <= ST_SEND;
              end else begin
                sda_oe_o  <= 1'b0;
                word_next <= 1'b1;
                state     <= ST_RECV;
              end
            end
          end
          ST_RECV_ACK: begin
            if (ev_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_RECV;
            end
          end
          ST_SEND: begin
            if (ev_rise && (bitcnt < 4'd8)) bitcnt <= bitcnt + 4'd1;
            if (ev_fall) begin
              if (byte_full(bitcnt)) begin
                sda_oe_o <= 1'b0;
                state    <= ST_SEND_ACK;
              end else if (tx_shift) begin
                sda_oe_o <= !tx_next_bit;
              end
            end
          end
          ST_SEND_ACK: begin
            if (ev_rise) master_ack <= !sda_i;
            if (ev_fall) begin
              bitcnt <= '0;
              if (master_ack) begin
                sda_oe_o <= !tx_data_i[7];
                state    <= ST_SEND;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tws_slave_engine_chk.sv
module tws_slave_engine_chk #(
  parameter int WRITE_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_o,
  input logic wr_commit_o,
  input logic addr_hit_o,
  input logic rx_valid_o,
  input logic ev_start
);
  logic [31:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 32'd1;
    else busy_run <= '0;
  end

  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);

  p_no_hit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !addr_hit_o);

  p_sda_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |=> busy_o);

  p_busy_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_commit_o));

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == 32'(WRITE_CYCLES)));

  p_hit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit_o |=> !addr_hit_o);

  p_start_no_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !rx_valid_o);
endmodule

bind tws_slave_engine tws_slave_engine_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .busy_o      (busy_o),
  .wr_commit_o (wr_commit_o),
  .addr_hit_o  (addr_hit_o),
  .rx_valid_o  (rx_valid_o),
  .ev_start    (ev_start)
);

// File: tb/tws_slave_engine_test.sv
module tws_slave_engine_test;
  localparam int WC = 200;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda_m;
  logic [2:0] strap;
  logic [7:0] tx_data;
  logic sda_oe, addr_hit, rw, rx_valid, rx_first, tx_take, busy, commit;
  logic [7:0] rx_data;
  wire sda_bus = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  int take_cnt = 0, rx_cnt = 0, commit_cnt = 0, busy_len = 0;
  logic oe_in_busy = 1'b0;
  logic [8:0] rx_log [8];

  always #5 clk = ~clk;

  tws_slave_engine #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .tx_data_i(tx_data), .sda_oe_o(sda_oe), .addr_hit_o(addr_hit), .rw_o(rw),
    .rx_valid_o(rx_valid), .rx_first_o(rx_first), .rx_data_o(rx_data),
    .tx_take_o(tx_take), .busy_o(busy), .wr_commit_o(commit)
  );

  function automatic logic [7:0] tx_pattern(input int i);
    return 8'((i * 19 + 90) % 256);
  endfunction

  always_comb tx_data = tx_pattern(take_cnt);

  always @(posedge clk) begin
    if (tx_take) take_cnt <= take_cnt + 1;
    if (rx_valid) begin
      rx_log[rx_cnt % 8] <= {rx_first, rx_data};
      rx_cnt <= rx_cnt + 1;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
    if (busy) busy_len <= busy_len + 1;
    if (busy && sda_oe) oe_in_busy <= 1'b1;
  end

  // {strap, address byte, expected acknowledge}
  localparam logic [11:0] VEC [9] = '{
    {3'b101, 8'hAA, 1'b1}, {3'b101, 8'hAB, 1'b1}, {3'b101, 8'hA8, 1'b0},
    {3'b000, 8'hA0, 1'b1}, {3'b000, 8'hA1, 1'b1}, {3'b111, 8'hAE, 1'b1},
    {3'b111, 8'hAC, 1'b0}, {3'b010, 8'hB4, 1'b0}, {3'b010, 8'h24, 1'b0}
  };

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_m = 1'b0; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h(H);
    scl = 1'b1; wait_h(H);
    sda_m = 1'b1; wait_h(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_h(H);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wait_h(H);
    scl = 1'b1; wait_h(H / 2);
    ack = !sda_bus;
    wait_h(H - H / 2);
    scl = 1'b0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_h(H);
      scl = 1'b1; wait_h(H / 2);
      b[i] = sda_bus;
      wait_h(H - H / 2);
      scl = 1'b0;
    end
    sda_m = !give_ack; wait_h(H);
    scl = 1'b1; wait_h(H);
    scl = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL all: watchdog expired, actual hung run, expected completion");
    summary();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int t0, r0, c0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 3'b000;
    wait_h(5);
    check("R11 released in reset", 32'(sda_oe), 0);
    check("R5 idle in reset", 32'(busy), 0);
    rst_n = 1'b1;
    wait_h(5);

    // R1 R2 R3: address table
    for (int v = 0; v < 9; v++) begin
      strap = VEC[v][11:9];
      bus_start();
      write_byte(VEC[v][8:1], ack);
      check($sformatf("R1/R2/R3 vector %0d ack", v), 32'(ack), 32'(VEC[v][0]));
      if (ack && VEC[v][1]) read_byte(1'b0, d);
      bus_stop();
      check($sformatf("R12 vector %0d no busy", v), 32'(busy), 0);
      wait_h(3);
    end

    // R4 R5: write with payload
    strap = 3'b011;
    r0 = rx_cnt; c0 = commit_cnt; busy_len = 0;
    bus_start();
    write_byte(8'hA6, ack); check("R3 write address ack", 32'(ack), 1);
    write_byte(8'h3C, ack); check("R4 word byte ack", 32'(ack), 1);
    write_byte(8'h81, ack); check("R4 data byte ack", 32'(ack), 1);
    write_byte(8'h7E, ack); check("R4 data byte 2 ack", 32'(ack), 1);
    bus_stop();
    check("R4 rx count", 32'(rx_cnt - r0), 3);
    check("R4 word byte flagged", 32'(rx_log[r0 % 8]), 32'({1'b1, 8'h3C}));
    check("R4 data byte", 32'(rx_log[(r0 + 1) % 8]), 32'({1'b0, 8'h81}));
    check("R4 data byte 2", 32'(rx_log[(r0 + 2) % 8]), 32'({1'b0, 8'h7E}));
    wait_h(3);
    check("R5 commit pulse", 32'(commit_cnt - c0), 1);
    check("R5 busy after stop", 32'(busy), 1);

    // R6: poll during busy
    bus_start();
    write_byte(8'hA6, ack);
    check("R6 poll while busy", 32'(ack), 0);
    bus_stop();
    while (busy) @(negedge clk);
    check("R5 busy length", 32'(busy_len), 32'(WC));
    check("R6 line never driven in busy", 32'(oe_in_busy), 0);

    // R7: poll after completion (read direction)
    bus_start();
    write_byte(8'hA7, ack);
    check("R7 poll ack after cycle", 32'(ack), 1);
    read_byte(1'b0, d);
    bus_stop();

    // R8 R9 R12: pointer write, repeated start, read three bytes
    c0 = commit_cnt;
    bus_start();
    write_byte(8'hA6, ack);
    write_byte(8'h10, ack);
    bus_start();
    write_byte(8'hA7, ack); check("R3 read address ack", 32'(ack), 1);
    t0 = take_cnt;
    read_byte(1'b1, d); check("R8 byte 0", 32'(d), 32'(tx_pattern(t0)));
    read_byte(1'b1, d); check("R8 byte 1", 32'(d), 32'(tx_pattern(t0 + 1)));
    read_byte(1'b0, d); check("R9 last byte", 32'(d), 32'(tx_pattern(t0 + 2)));
    wait_h(2);
    check("R9 released after nack", 32'(sda_oe), 0);
    check("R9 no further capture", 32'(take_cnt - t0), 3);
    bus_stop();
    wait_h(3);
    check("R12 pointer-only no commit", 32'(commit_cnt - c0), 0);
    check("R12 pointer-only no busy", 32'(busy), 0);

    // R10: start and stop part way through a byte
    r0 = rx_cnt; c0 = commit_cnt;
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    write_byte(8'hA6, ack);
    check("R10 address after mid-byte start", 32'(ack), 1);
    write_byte(8'h55, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    wait_h(3);
    check("R10 partial byte dropped", 32'(rx_cnt - r0), 1);
    check("R10 no commit after mid-byte stop", 32'(commit_cnt - c0), 0);
    check("R10 no busy after mid-byte stop", 32'(busy), 0);

    summary();
  end
endmodule